// File: doc/BRIEF.md
# Ethernet Receive Preamble Checker

This block sits on the byte-wide receive path between the physical-layer interface and the rest of the receive MAC. It follows each frame as a run of bytes with `rx_dv` held high. It finds the start-of-frame delimiter and, under two separate enables, checks the preamble bytes that come before it. One enable checks what each preamble byte contains. The other caps how many preamble bytes a frame may have. A frame that meets the enabled rules is forwarded from the byte after the delimiter, as a valid/last byte stream. A frame that breaks a rule is dropped as a whole. In that case the block raises a one-cycle drop pulse with a reason code and then ignores the line until `rx_dv` falls.

The controller has four named states. `ST_IDLE` waits for a frame. `ST_PRE` is inside the preamble. `ST_PAY` forwards payload. `ST_DRAIN` swallows the rest of a rejected frame.

The transitions are as follows:
- idle→pre: a non-delimiter byte passes the checks.
- idle/pre→pay: the delimiter byte 0xD5 is seen.
- idle/pre→drain: a preamble byte fails an enabled check.
- pre→idle: `rx_dv` falls before any delimiter.
- pay→idle: `rx_dv` falls.
- drain→idle: `rx_dv` falls.

Every other case holds the current state.

Top module: `eth_rx_preamble_check`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `drop_pulse` are 0 and `drop_why` is 2'b00.
- R2: The first byte equal to 0xD5 while `rx_dv` is high ends the preamble. That byte is not forwarded. The bytes after it, up to the fall of `rx_dv`, appear on `out_data` in order, one per `out_valid` cycle. A frame with no bytes after the delimiter produces no output.
- R3: `out_last` is high together with `out_valid` on exactly the final payload byte. Each payload byte is presented on the clock edge that samples the next byte, or on the edge that samples `rx_dv` low.
- R4: With `pure_en` high, a preamble byte other than 0x55 drops the frame with reason 2'b01.
- R5: With `pure_en` high, a preamble byte received with `rx_er` high drops the frame with reason 2'b01.
- R6: With `long_en` high, a frame whose preamble reaches MAX_PRE (12) bytes is dropped with reason 2'b10 when its MAX_PRE-th byte arrives. A frame with a preamble of MAX_PRE-1 bytes is accepted.
- R7: A check whose enable is low has no effect. With both enables low, a preamble of any length and content is accepted.
- R8: A dropped frame produces no output at all. Every remaining byte of that frame, including any later 0xD5, is ignored until `rx_dv` falls.
- R9: A drop raises `drop_pulse` for exactly one cycle, on the edge after the failing byte is sampled. If both checks fail on the same byte, the reason is 2'b01.
- R10: If `rx_dv` falls before any delimiter, the block returns to idle with no output and no drop pulse.
- R11: A delimiter as the very first byte of a frame, which is a zero-length preamble, is accepted under both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_dv | input | 1 | Byte valid; high for the whole frame |
| rx_er | input | 1 | Receive error flag for the current byte |
| pure_en | input | 1 | Enable the preamble content check |
| long_en | input | 1 | Enable the preamble length cap |
| out_data | output | 8 | Forwarded payload byte |
| out_valid | output | 1 | `out_data` holds a payload byte |
| out_last | output | 1 | Final payload byte of the frame |
| drop_pulse | output | 1 | One-cycle frame-rejection pulse |
| drop_why | output | 2 | Reason: 01 content, 10 length, 00 none |

## Verification
The bench builds the block with its default parameters: MAX_PRE of 12, a preamble byte of 0x55 and a delimiter of 0xD5. With a cap of 12, short frames can reach both sides of the length boundary (11 accepted, 12 dropped). They can also reach a 20-byte preamble that passes the saturating counter when the cap is off. The small cap also lets a failing content byte coincide with the length limit on the same byte, which exercises the reason priority.

// File: rtl/rxpc_pkg.sv
package rxpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_PAY   = 2'd2,
        ST_DRAIN = 2'd3
    } rxpc_state_e;

    typedef enum logic [1:0] {
        WHY_NONE    = 2'b00,
        WHY_CONTENT = 2'b01,
        WHY_LENGTH  = 2'b10
    } rxpc_why_e;

endpackage

// File: rtl/rxpc_byte_class.sv
module rxpc_byte_class #(
    parameter int              W        = 8,
    parameter logic [W-1:0]    PRE_BYTE = 8'h55,
    parameter logic [W-1:0]    SFD_BYTE = 8'hD5
) (
    input  logic [W-1:0] data,
    input  logic         er,
    output logic         is_sfd,
    output logic         is_clean
);
    // A preamble byte is clean when it has the fill pattern and no error.
    assign is_sfd   = (data == SFD_BYTE);
    assign is_clean = (data == PRE_BYTE) && !er;
endmodule

// File: rtl/rxpc_pre_count.sv
module rxpc_pre_count #(
    parameter int LIMIT = 12,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_cap
);
    logic [CW-1:0] cnt;

    // Counts preamble bytes accepted so far, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt < CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The byte being looked at now would make the length LIMIT.
    assign at_cap = (cnt >= CW'(LIMIT - 1));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));
endmodule

// File: rtl/eth_rx_preamble_check.sv
module eth_rx_preamble_check #(
    parameter int          MAX_PRE  = 12,
    parameter logic [7:0]  PRE_BYTE = 8'h55,
    parameter logic [7:0]  SFD_BYTE = 8'hD5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_data,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic       pure_en,
    input  logic       long_en,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_last,
    output logic       drop_pulse,
    output logic [1:0] drop_why
);
    import rxpc_pkg::*;

    rxpc_state_e state, nxt;
    rxpc_why_e   why_q;
    logic        is_sfd, is_clean, at_cap;
    logic        pre_step, fail_content, fail_len, drop_now;
    logic        cnt_clr, cnt_inc;
    logic [7:0]  hold_data;
    logic        hold_full;

    rxpc_byte_class #(.W(8), .PRE_BYTE(PRE_BYTE), .SFD_BYTE(SFD_BYTE)) u_class (
        .data     (rx_data),
        .er       (rx_er),
        .is_sfd   (is_sfd),
        .is_clean (is_clean)
    );

    rxpc_pre_count #(.LIMIT(MAX_PRE)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .at_cap (at_cap)
    );

    // Preamble checks, evaluated on every byte seen in idle or preamble.
    always_comb begin
        pre_step     = rx_dv && ((state == ST_IDLE) || (state == ST_PRE));
        fail_content = pure_en && !is_clean;
        fail_len     = long_en && at_cap;
        drop_now     = pre_step && !is_sfd && (fail_content || fail_len);
        nxt          = state;
        unique case (state)
            ST_IDLE, ST_PRE: begin
                if (!rx_dv)                       nxt = ST_IDLE;
                else if (is_sfd)                  nxt = ST_PAY;
                else if (fail_content || fail_len) nxt = ST_DRAIN;
                else                              nxt = ST_PRE;
            end
            ST_PAY:   nxt = rx_dv ? ST_PAY : ST_IDLE;
            ST_DRAIN: nxt = rx_dv ? ST_DRAIN : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        cnt_clr = (nxt != ST_PRE);
        cnt_inc = pre_step && !is_sfd;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Outputs: one-byte hold so the final byte can carry out_last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            drop_pulse <= 1'b0;
            why_q      <= WHY_NONE;
            hold_data  <= '0;
            hold_full  <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            drop_pulse <= drop_now;
            why_q      <= !drop_now ? WHY_NONE
                        : (fail_content ? WHY_CONTENT : WHY_LENGTH);
            if (state == ST_PAY) begin
                if (rx_dv) begin
                    if (hold_full) begin
                        out_valid <= 1'b1;
                        out_data  <= hold_data;
                    end
                    hold_data <= rx_data;
                    hold_full <= 1'b1;
                end else begin
                    if (hold_full) begin
                        out_valid <= 1'b1;
                        out_last  <= 1'b1;
                        out_data  <= hold_data;
                    end
                    hold_full <= 1'b0;
                end
            end
        end
    end

    assign drop_why = why_q;

    // R2
    out_from_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state) == ST_PAY));
    // R3
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && !$past(rx_dv)));
    // R4
    content_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse && (drop_why == WHY_CONTENT)) |-> $past(pure_en));
    // R6
    length_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse && (drop_why == WHY_LENGTH)) |-> $past(long_en));
    // R8
    drain_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> !out_valid);
    // R9
    drop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> !drop_pulse);
endmodule

// File: tb/eth_rx_preamble_check_test.sv
module eth_rx_preamble_check_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] rx_data;
    logic       rx_dv, rx_er, pure_en, long_en;
    logic [7:0] out_data;
    logic       out_valid, out_last, drop_pulse;
    logic [1:0] drop_why;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [8:0] exp_byte[$];
    string      exp_byte_req[$];
    logic [1:0] exp_drop[$];
    string      exp_drop_req[$];

    always #2 clk = ~clk;

    eth_rx_preamble_check uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_dv(rx_dv),
        .rx_er(rx_er), .pure_en(pure_en), .long_en(long_en),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .drop_pulse(drop_pulse), .drop_why(drop_why)
    );

    // Monitor: pops expected bytes and drops as the design produces them.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            if (out_valid) begin
                checks++;
                if (exp_byte.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected byte: actual %h last %b expected none",
                             out_data, out_last);
                end else begin
                    logic [8:0] e;
                    string r;
                    e = exp_byte.pop_front();
                    r = exp_byte_req.pop_front();
                    if ({out_last, out_data} !== e) begin
                        errors++;
                        $display("FAIL %s byte: actual last=%b data=%h expected last=%b data=%h",
                                 r, out_last, out_data, e[8], e[7:0]);
                    end
                end
            end else if (out_last) begin
                checks++; errors++;
                $display("FAIL R3 out_last without out_valid: actual 1 expected 0");
            end
            if (drop_pulse) begin
                checks++;
                if (exp_drop.size() == 0) begin
                    errors++;
                    $display("FAIL R9 unexpected drop: actual why=%b expected none", drop_why);
                end else begin
                    logic [1:0] w;
                    string r;
                    w = exp_drop.pop_front();
                    r = exp_drop_req.pop_front();
                    if (drop_why !== w) begin
                        errors++;
                        $display("FAIL %s drop reason: actual %b expected %b", r, drop_why, w);
                    end
                end
            end
        end
    end

    // Driver: computes the expected result from the requirements, then drives.
    task automatic send_frame(input int npre, input int bad_at, input int er_at,
                              input bit sfd, input int npay, input bit pe,
                              input bit le, input string req);
        int fail_at = -1;
        logic [1:0] why = 2'b00;
        for (int i = 0; i < npre; i++) begin
            bit c = pe && (i == bad_at || i == er_at);
            bit l = le && (i + 1 >= 12);
            if (fail_at < 0 && (c || l)) begin
                fail_at = i;
                why = c ? 2'b01 : 2'b10;
            end
        end
        if (fail_at >= 0) begin
            exp_drop.push_back(why);
            exp_drop_req.push_back(req);
        end else if (sfd) begin
            for (int k = 0; k < npay; k++) begin
                logic [7:0] v = 8'(k * 29 + npre * 7 + 3);
                exp_byte.push_back({(k == npay - 1), v});
                exp_byte_req.push_back(req);
            end
        end
        @(negedge clk);
        pure_en = pe; long_en = le;
        for (int i = 0; i < npre; i++) begin
            rx_dv = 1'b1;
            rx_data = (i == bad_at) ? 8'h5A : 8'h55;
            rx_er = (i == er_at);
            @(negedge clk);
        end
        rx_er = 1'b0;
        if (sfd) begin
            rx_dv = 1'b1; rx_data = 8'hD5;
            @(negedge clk);
            for (int k = 0; k < npay; k++) begin
                rx_data = 8'(k * 29 + npre * 7 + 3);
                @(negedge clk);
            end
        end
        rx_dv = 1'b0; rx_data = 8'h00;
        repeat (4) @(negedge clk);
        checks++;
        if (exp_byte.size() != 0 || exp_drop.size() != 0) begin
            errors++;
            $display("FAIL %s pending items: actual bytes=%0d drops=%0d expected 0 0",
                     req, exp_byte.size(), exp_drop.size());
            exp_byte.delete(); exp_byte_req.delete();
            exp_drop.delete(); exp_drop_req.delete();
        end
    endtask

    initial begin
        rst_n = 1'b0; rx_data = 8'h00; rx_dv = 1'b0; rx_er = 1'b0;
        pure_en = 1'b0; long_en = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_last !== 1'b0 || drop_pulse !== 1'b0 || drop_why !== 2'b00) begin
            errors++;
            $display("FAIL R1 reset: actual %b%b%b%b expected 0000",
                     out_valid, out_last, drop_pulse, drop_why);
        end
        rst_n = 1'b1;
        @(negedge clk);
        send_frame(7,  -1, -1, 1, 5, 1, 1, "R2 R3");
        send_frame(0,  -1, -1, 1, 3, 1, 1, "R11");
        send_frame(7,  -1, -1, 1, 1, 1, 1, "R3");
        send_frame(7,  -1, -1, 1, 0, 1, 1, "R2");
        send_frame(7,   3, -1, 1, 6, 1, 0, "R4");
        send_frame(7,  -1,  2, 1, 6, 1, 1, "R5");
        send_frame(11, -1, -1, 1, 4, 0, 1, "R6");
        send_frame(12, -1, -1, 1, 4, 0, 1, "R6");
        send_frame(15, -1, -1, 1, 4, 1, 1, "R6 R8");
        send_frame(20,  4,  6, 1, 4, 0, 0, "R7");
        send_frame(20, -1, -1, 1, 3, 1, 0, "R7");
        send_frame(9,   2,  5, 1, 3, 0, 1, "R7");
        send_frame(5,  -1, -1, 0, 0, 1, 1, "R10");
        send_frame(14, 11, -1, 1, 3, 1, 1, "R9");
        send_frame(4,   0, -1, 1, 8, 1, 1, "R8 R9");
        send_frame(6,  -1, -1, 1, 2, 1, 1, "R2");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule